// File: doc/BRIEF.md
# Register-Triggered MDIO Command Engine

This block turns a single 32-bit command word into one clause-22 management frame on an MDIO bus. Software writes the command word: it carries the read or write request flag, the 5-bit PHY and register addresses, the bus selector and, for writes, the 16 data bits. The engine derives MDC from the system clock, shifts the frame out most significant bit first, and releases the data line for the turnaround and data phases of a read. A read result is held in a separate 16-bit data register.

Two physical management buses hang off the engine: an internal and an external one. One bit of the command word chooses which one carries the frame. The other bus stays quiet. While a frame is in flight a busy status is shown, and further command writes are dropped.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the command register and the data register read 0, busy is low, and both MDC outputs and both data output enables are low.
- R2: A command write while idle is stored in the command register. It starts a frame, with busy high from the next cycle, only when exactly one of bit 31 (write request) and bit 30 (read request) is set. A word with both flags or neither stores without starting a frame.
- R3: Writing an all-zero word while idle clears the command register and starts nothing.
- R4: A command write while busy leaves the command register unchanged and produces no extra frame.
- R5: A write frame carries, MSB first: 32 ones, start 01, opcode 01, PHY address (command bits 29:25), register address (bits 24:20), turnaround 10, then data bits 15:0. The output enable is high for all 64 bits.
- R6: A read frame carries 32 ones, 01, opcode 10, PHY and register addresses. The output enable drops from the first turnaround bit (bit 46 of the frame) to the end. The 16 bits sampled on the MDC rising edges of frame bits 48..63 land MSB first in the data register when the frame ends.
- R7: Command bit 16 set sends the frame on the external bus, clear on the internal bus. The unused bus keeps MDC and output enable low.
- R8: MDC has a period of 2*HALF_DIV system cycles. The data output changes only on MDC falling edges, so it is stable at every rising edge.
- R9: Busy lasts exactly 128*HALF_DIV cycles per frame: 2560 cycles, or 25.6 us, at the defaults with a 100 MHz clock. This is within the 50 us transaction limit.
- R10: The data register changes only when a read frame completes. Write frames leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 32 | Command word written |
| cmd_o | output | 32 | Current command register contents |
| data_o | output | 16 | Read data register |
| busy_o | output | 1 | Frame in progress |
| int_mdc_o | output | 1 | Internal bus management clock |
| int_mdio_o | output | 1 | Internal bus data out |
| int_mdio_oe_o | output | 1 | Internal bus data output enable |
| int_mdio_i | input | 1 | Internal bus data in |
| ext_mdc_o | output | 1 | External bus management clock |
| ext_mdio_o | output | 1 | External bus data out |
| ext_mdio_oe_o | output | 1 | External bus data output enable |
| ext_mdio_i | input | 1 | External bus data in |

## Verification
The bench captures every frame at the MDC rising edges on both buses and compares bits, output enable and chosen bus against a queue of frames expected from the command words. A design that swapped the opcodes, misplaced an address field or kept driving through the read turnaround fails there. Read responses with only the top or only the bottom bit set catch a reversed or off-by-one sample window. Words with both flags set, the zero word and a write issued mid-frame check that nothing starts; an unexpected frame has no queue entry and is reported. Busy length and MDC spacing are measured to catch a wrong divider or a frame with a missing bit.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int CMD_W      = 32;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 5;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;  // first turnaround bit, frame order
  localparam int RDATA_POS  = 48;  // first data bit, frame order
  localparam int WR_BIT     = 31;
  localparam int RD_BIT     = 30;
  localparam int PHY_LSB    = 25;
  localparam int REG_LSB    = 20;
  localparam int BUS_BIT    = 16;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;

  typedef struct packed {
    logic              is_read;
    logic              ext_bus;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] wdata;
  } mdio_req_t;
endpackage

// File: rtl/mdio_cmd_regs.sv
module mdio_cmd_regs
  import mdio_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CMD_W-1:0] wdata_i,
  input  logic             busy_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic             start_o,
  output mdio_req_t        req_o
);
  logic [CMD_W-1:0] cmd_q;
  logic             accept;

  assign accept  = we_i && !busy_i;
  assign start_o = accept && (wdata_i[WR_BIT] ^ wdata_i[RD_BIT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_q <= '0;
    else if (accept) cmd_q <= wdata_i;
  end

  assign req_o.is_read = wdata_i[RD_BIT];
  assign req_o.ext_bus = wdata_i[BUS_BIT];
  assign req_o.phy     = wdata_i[PHY_LSB +: ADDR_W];
  assign req_o.regad   = wdata_i[REG_LSB +: ADDR_W];
  assign req_o.wdata   = wdata_i[DATA_W-1:0];
  assign cmd_o         = cmd_q;
endmodule

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_DIV = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] cnt_q;
  logic          mdc_q;
  logic          tick;

  assign tick = en_i && (cnt_q == DW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  mdio_req_t         req_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdi_i,
  output logic              busy_o,
  output logic              ext_o,
  output logic              mdo_o,
  output logic              oe_o,
  output logic              rd_done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int CNT_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] shift_q;
  logic [CNT_W-1:0]      bit_q;
  logic                  busy_q, rd_q, ext_q;
  logic [DATA_W-1:0]     rsh_q;
  logic [FRAME_BITS-1:0] frame_d;
  logic                  last_bit;

  always_comb begin
    if (req_i.is_read)
      frame_d = {{PRE_BITS{1'b1}}, 2'b01, OP_READ, req_i.phy, req_i.regad,
                 2'b00, {DATA_W{1'b0}}};
    else
      frame_d = {{PRE_BITS{1'b1}}, 2'b01, OP_WRITE, req_i.phy, req_i.regad,
                 2'b10, req_i.wdata};
  end

  assign last_bit = (bit_q == CNT_W'(FRAME_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      bit_q   <= '0;
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      ext_q   <= 1'b0;
      rsh_q   <= '0;
    end else if (start_i && !busy_q) begin
      shift_q <= frame_d;
      bit_q   <= '0;
      busy_q  <= 1'b1;
      rd_q    <= req_i.is_read;
      ext_q   <= req_i.ext_bus;
    end else if (busy_q) begin
      if (rise_i && rd_q && bit_q >= CNT_W'(RDATA_POS))
        rsh_q <= {rsh_q[DATA_W-2:0], mdi_i};
      if (fall_i) begin
        if (last_bit) begin
          busy_q <= 1'b0;
        end else begin
          bit_q   <= bit_q + 1'b1;
          shift_q <= {shift_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign ext_o     = ext_q;
  assign mdo_o     = shift_q[FRAME_BITS-1];
  assign oe_o      = busy_q && (!rd_q || bit_q < CNT_W'(TA_POS));
  assign rd_done_o = busy_q && fall_i && last_bit && rd_q;
  assign rdata_o   = rsh_q;
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_cmd_pkg::*;
#(
  parameter int HALF_DIV = 20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic [31:0] cmd_wdata_i,
  output logic [31:0] cmd_o,
  output logic [15:0] data_o,
  output logic        busy_o,
  output logic        int_mdc_o,
  output logic        int_mdio_o,
  output logic        int_mdio_oe_o,
  input  logic        int_mdio_i,
  output logic        ext_mdc_o,
  output logic        ext_mdio_o,
  output logic        ext_mdio_oe_o,
  input  logic        ext_mdio_i
);
  logic              start, busy, ext_sel, mdc, rise, fall, mdo, oe, mdi;
  logic              rd_done;
  logic [DATA_W-1:0] rdata, data_q;
  mdio_req_t         req;

  mdio_cmd_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(cmd_we_i), .wdata_i(cmd_wdata_i), .busy_i(busy),
    .cmd_o, .start_o(start), .req_o(req)
  );

  mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
    .clk_i, .rst_ni, .en_i(busy),
    .mdc_o(mdc), .rise_o(rise), .fall_o(fall)
  );

  mdio_frame_seq u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .req_i(req), .rise_i(rise), .fall_i(fall), .mdi_i(mdi),
    .busy_o(busy), .ext_o(ext_sel), .mdo_o(mdo), .oe_o(oe),
    .rd_done_o(rd_done), .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (rd_done) data_q <= rdata;
  end

  assign mdi = ext_sel ? ext_mdio_i : int_mdio_i;

  assign int_mdc_o     = mdc && !ext_sel;
  assign int_mdio_o    = mdo && !ext_sel;
  assign int_mdio_oe_o = oe  && !ext_sel;
  assign ext_mdc_o     = mdc && ext_sel;
  assign ext_mdio_o    = mdo && ext_sel;
  assign ext_mdio_oe_o = oe  && ext_sel;

  assign data_o = data_q;
  assign busy_o = busy;
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk #(
  parameter int MAX_BUSY = 5000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_we_i,
  input logic [31:0] cmd_wdata_i,
  input logic [31:0] cmd_o,
  input logic [15:0] data_o,
  input logic        busy_o,
  input logic        int_mdc_o,
  input logic        int_mdio_oe_o,
  input logic        ext_mdc_o,
  input logic        ext_mdio_oe_o
);
  logic [31:0] busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len <= '0;
    else if (busy_o) busy_len <= busy_len + 1'b1;
    else             busy_len <= '0;
  end

  a_r2_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && !busy_o && (cmd_wdata_i[31] ^ cmd_wdata_i[30]) |=> busy_o);

  a_r2_no_flag_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && !busy_o && !(cmd_wdata_i[31] ^ cmd_wdata_i[30]) |=> !busy_o);

  a_r3_zero_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && !busy_o && cmd_wdata_i == 32'h0 |=> cmd_o == 32'h0);

  a_r4_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && busy_o |=> $stable(cmd_o));

  a_r7_one_mdc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({int_mdc_o, ext_mdc_o}));

  a_r7_one_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({int_mdio_oe_o, ext_mdio_oe_o}));

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !int_mdc_o && !ext_mdc_o && !int_mdio_oe_o && !ext_mdio_oe_o);

  a_r10_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(data_o));

  a_r9_deadline: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_len <= 32'(MAX_BUSY));
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk #(.MAX_BUSY(5000)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_we_i(cmd_we_i), .cmd_wdata_i(cmd_wdata_i),
  .cmd_o(cmd_o), .data_o(data_o), .busy_o(busy_o),
  .int_mdc_o(int_mdc_o), .int_mdio_oe_o(int_mdio_oe_o),
  .ext_mdc_o(ext_mdc_o), .ext_mdio_oe_o(ext_mdio_oe_o)
);

// File: tb/mdio_cmd_engine_bench.sv
`timescale 1ns/1ps
module mdio_cmd_engine_bench;
  localparam int HALF = 20;

  typedef struct {
    bit [63:0] bits;
    bit [63:0] oe;
    bit        ext;
    bit        rd;
  } frame_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] cmd;
  logic [15:0] data;
  logic        busy;
  logic        imdc, imdo, ioe, emdc, emdo, eoe;
  logic        mdi;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit finished = 0;
  logic [15:0] resp = '0;
  frame_t exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdio_cmd_engine u_mdio_cmd_engine (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(we), .cmd_wdata_i(wdata),
    .cmd_o(cmd), .data_o(data), .busy_o(busy),
    .int_mdc_o(imdc), .int_mdio_o(imdo), .int_mdio_oe_o(ioe), .int_mdio_i(mdi),
    .ext_mdc_o(emdc), .ext_mdio_o(emdo), .ext_mdio_oe_o(eoe), .ext_mdio_i(mdi)
  );

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: capture frames at MDC rising edges
  int        rises = 0;
  logic [63:0] cap_bits, cap_oe;
  bit        cap_ext, per_bad, quiet_bad;
  logic      pimdc = 0, pemdc = 0;
  int        last_rise = 0;

  assign mdi = (rises >= 48 && rises < 64) ? resp[63 - rises] : 1'b1;

  always @(negedge clk) begin
    bit rose_i, rose_e;
    rose_i = imdc && !pimdc;
    rose_e = emdc && !pemdc;
    pimdc <= imdc;
    pemdc <= emdc;
    if (rises > 0 && ((cap_ext && (imdc || ioe)) || (!cap_ext && (emdc || eoe))))
      quiet_bad = 1;
    if (rose_i || rose_e) begin
      if (rises == 0) begin
        cap_ext = rose_e; per_bad = 0; quiet_bad = 0;
      end else if (cyc - last_rise != 2*HALF) per_bad = 1;
      last_rise = cyc;
      cap_bits[63 - rises] = rose_e ? emdo : imdo;
      cap_oe[63 - rises]   = rose_e ? eoe : ioe;
      rises = rises + 1;
      if (rises == 64) begin
        if (exp_q.size() == 0) begin
          check(0, "R4", "unexpected frame", cap_bits, 64'h0);
        end else begin
          frame_t e;
          e = exp_q.pop_front();
          check(cap_oe == e.oe, e.rd ? "R6" : "R5", "output enable", cap_oe, e.oe);
          check((cap_bits & e.oe) == (e.bits & e.oe), e.rd ? "R6" : "R5", "frame bits",
                cap_bits & e.oe, e.bits & e.oe);
          check(cap_ext == e.ext, "R7", "bus chosen", 64'(cap_ext), 64'(e.ext));
          check(!quiet_bad, "R7", "unused bus quiet", 64'(quiet_bad), 64'h0);
          check(!per_bad, "R8", "MDC period", 64'(per_bad), 64'h0);
        end
        rises = 0;
      end
    end
  end

  function automatic frame_t expect_frame(logic [31:0] w);
    frame_t f;
    f.rd  = w[30];
    f.ext = w[16];
    if (f.rd) begin
      f.bits = {32'hFFFF_FFFF, 2'b01, 2'b10, w[29:25], w[24:20], 18'h0};
      f.oe   = {{46{1'b1}}, 18'h0};
    end else begin
      f.bits = {32'hFFFF_FFFF, 2'b01, 2'b01, w[29:25], w[24:20], 2'b10, w[15:0]};
      f.oe   = '1;
    end
    return f;
  endfunction

  task automatic write_cmd(logic [31:0] w);
    @(negedge clk);
    we = 1'b1; wdata = w;
    @(negedge clk);
    we = 1'b0;
  endtask

  // driver: push expectation, issue, wait for end of frame
  task automatic run_frame(logic [31:0] w, logic [15:0] r, output int blen);
    resp = r;
    exp_q.push_back(expect_frame(w));
    write_cmd(w);
    blen = 0;
    while (busy) begin blen++; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int blen;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cmd == 0 && data == 0 && !busy, "R1", "regs after reset", {cmd, data}, 64'h0);
    check(!imdc && !emdc && !ioe && !eoe, "R1", "buses idle", {imdc, emdc, ioe, eoe}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5 R7 R8 R9: write, internal bus
    run_frame(32'h8000_0000 | (32'd5 << 25) | (32'd3 << 20) | 32'hA5C3, 16'h0, blen);
    check(blen == 128*HALF, "R9", "busy length", 64'(blen), 64'(128*HALF));
    check(blen <= 5000, "R9", "50us bound", 64'(blen), 64'd5000);
    check(data == 16'h0, "R10", "data after write", 64'(data), 64'h0);

    // R6 R7: read, external bus
    run_frame(32'h4000_0000 | (32'd31 << 25) | (32'd17 << 20) | 32'h0001_0000, 16'hBEEF, blen);
    check(data == 16'hBEEF, "R6", "read data", 64'(data), 64'hBEEF);

    // R10: write on external leaves data
    run_frame(32'h8001_0000 | (32'd1 << 25) | (32'd30 << 20) | 32'h0F0F, 16'h1234, blen);
    check(data == 16'hBEEF, "R10", "data held across write", 64'(data), 64'hBEEF);

    // R6 boundary responses on internal bus
    run_frame(32'h4000_0000 | (32'd2 << 25) | (32'd0 << 20), 16'h8000, blen);
    check(data == 16'h8000, "R6", "read MSB only", 64'(data), 64'h8000);
    run_frame(32'h4000_0000 | (32'd0 << 25) | (32'd31 << 20), 16'h0001, blen);
    check(data == 16'h0001, "R6", "read LSB only", 64'(data), 64'h0001);

    // R2: both flags set - stored, no frame
    write_cmd(32'hC123_4567);
    repeat (5) @(negedge clk);
    check(cmd == 32'hC123_4567, "R2", "both flags stored", 64'(cmd), 64'hC123_4567);
    check(!busy, "R2", "both flags no busy", 64'(busy), 64'h0);
    write_cmd(32'h0001_ABCD);
    repeat (5) @(negedge clk);
    check(!busy && cmd == 32'h0001_ABCD, "R2", "no flag no start", 64'(cmd), 64'h0001_ABCD);

    // R3: zero word clears
    write_cmd(32'h0);
    repeat (5) @(negedge clk);
    check(cmd == 0 && !busy, "R3", "zero word clears", {31'h0, busy, cmd}, 64'h0);

    // R4: write while busy ignored
    resp = 16'h5A5A;
    exp_q.push_back(expect_frame(32'h4000_0000 | (32'd9 << 25) | (32'd4 << 20)));
    write_cmd(32'h4000_0000 | (32'd9 << 25) | (32'd4 << 20));
    held = 16'h5A5A;
    repeat (300) @(negedge clk);
    write_cmd(32'h8001_FFFF);
    check(cmd == (32'h4000_0000 | (32'd9 << 25) | (32'd4 << 20)), "R4", "cmd held while busy",
          64'(cmd), 64'(32'h4000_0000 | (32'd9 << 25) | (32'd4 << 20)));
    while (busy) @(negedge clk);
    check(data == held, "R4", "frame unaffected", 64'(data), 64'(held));
    repeat (200) @(negedge clk);
    check(exp_q.size() == 0 && !busy, "R4", "no extra frame", 64'(exp_q.size()), 64'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule